// File: doc/BRIEF.md
# Word-Stepped Sequential Integer Core

This block is a small non-pipelined processor that completes one 32-bit instruction on every clock edge on which it is free to advance. Instructions come from an external instruction ROM through a combinational read port that is indexed in words. Loads and stores use a private data memory of `DMEM_WORDS` words. The core holds 32 general registers and a program counter that counts instruction words. It decodes three instruction formats: register-register, immediate and jump. It executes arithmetic, logic, compare, shift, load, store, branch and jump instructions, and it has two extra opcodes, one that stops the core and one that emits a register value.

Emitted values leave through a valid/ready stream. A value is offered with `out_valid` and is transferred on a rising edge where `out_ready` is also high. While an offered value has not been taken, `out_data` does not change and the core executes nothing, so the stream never loses or overwrites a value. The core stops when it executes the stop opcode, when the PC reaches or passes `prog_len`, or when it meets an encoding it does not know. In the last case it also raises `fault`. Once stopped, it stays stopped until reset.

Top module: `sc_core`

## Requirements
- R1: While reset is active and right after it ends, the PC is 0 (`imem_addr` is 0), all registers are 0, and `stopped`, `fault` and `out_valid` are low.
- R2: Instruction fields sit at opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0], imm [15:0] and jump offset [25:0]. Opcode 0 is register-register, opcodes 0x02 and 0x03 are jump format, and every other opcode is immediate format.
- R3: A register-register instruction writes rd with rs OP rt for these funct codes: 0x20 add, 0x22 sub, 0x24 and, 0x25 or, 0x26 xor, 0x28 equal, 0x29 not-equal, 0x2a less-than, 0x2c less-or-equal, 0x04 shift left, 0x06 logical shift right and 0x07 arithmetic shift right. Compares are unsigned and give 1 or 0. The shift amount is rt[4:0]. Funct 0x00 changes nothing.
- R4: An immediate instruction writes rt with rs OP imm for these opcodes: 0x08 add, 0x0a sub, 0x0c and, 0x0d or, 0x0e xor, 0x14/0x16/0x17 shifts, 0x18 equal, 0x19 not-equal, 0x1a less-than and 0x1c less-or-equal. The immediate is sign-extended for every one of these except 0x0e, which zero-extends it. All 32 registers, register 0 included, are writable.
- R5: Opcode 0x0f writes rt with imm shifted left by 16 bits.
- R6: Opcode 0x2b stores rt to the data word at (rs + sign-extended imm) modulo `DMEM_WORDS`. Opcode 0x23 loads rt from that same word.
- R7: Opcode 0x04 is taken when rs is zero and opcode 0x05 is taken when rs is non-zero. A taken branch moves the PC to PC+1 plus the sign-extended imm. A branch that is not taken moves the PC to PC+1.
- R8: Opcode 0x12 moves the PC to the value of rs. Opcode 0x13 does the same and also writes PC+4 to register 31. The jump target is the value rs had before that write.
- R9: Opcode 0x02 moves the PC to PC+1 plus the sign-extended 26-bit offset. Opcode 0x03 does the same and also writes PC+4 to register 31.
- R10: Opcode 0x31 offers the value of rs on `out_data` with `out_valid`. While `out_valid` is high and `out_ready` is low, `out_data` and the PC hold still. Offered values are delivered once each and in program order.
- R11: Opcode 0x30 raises `stopped` with `fault` low. The PC stays at that instruction and `stopped` stays high until reset.
- R12: When the PC is greater than or equal to `prog_len`, the core raises `stopped` with `fault` low and executes nothing further.
- R13: An unknown opcode, or an unknown funct in register-register format, raises both `stopped` and `fault`. The PC stays at that instruction and the instruction writes no register and no memory word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_len | input | 32 | Number of instruction words in the program |
| imem_addr | output | IADDR_W | Word index of the instruction being fetched (the PC) |
| imem_data | input | 32 | Instruction word at `imem_addr`, combinational |
| out_valid | output | 1 | An emitted value is being offered |
| out_ready | input | 1 | Consumer accepts the offered value |
| out_data | output | 32 | Emitted register value |
| stopped | output | 1 | Core has stopped; high until reset |
| fault | output | 1 | Core stopped on an unknown encoding |

## Verification
The interesting coincidence is a stream transfer that completes on the same edge on which the core executes its next instruction. That next instruction may itself be an emit, which reloads `out_valid` and `out_data` at the moment the old value leaves, or it may be the stop instruction, which should not lose the value in flight. The bench provokes this with back-to-back emit instructions and an emit placed directly before the stop. It toggles `out_ready` in a repeating pattern so that some transfers land on the issue edge and others are held back. A scoreboard judges the result: every delivered value must match the next expected value in program order, and none may be left over once the core has stopped. On every stalled cycle the bench also confirms that the fetch index has not moved.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int XLEN   = 32;
  localparam int RIDX_W = 5;
  localparam int NREG   = 1 << RIDX_W;
  localparam logic [RIDX_W-1:0] LINK_REG = RIDX_W'(NREG - 1);

  localparam logic [5:0] OPC_REG   = 6'h00;
  localparam logic [5:0] OPC_JMP   = 6'h02;
  localparam logic [5:0] OPC_JMPL  = 6'h03;
  localparam logic [5:0] OPC_BEZ   = 6'h04;
  localparam logic [5:0] OPC_BNZ   = 6'h05;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_SUBI  = 6'h0a;
  localparam logic [5:0] OPC_ANDI  = 6'h0c;
  localparam logic [5:0] OPC_ORI   = 6'h0d;
  localparam logic [5:0] OPC_XORI  = 6'h0e;
  localparam logic [5:0] OPC_HIGH  = 6'h0f;
  localparam logic [5:0] OPC_JREG  = 6'h12;
  localparam logic [5:0] OPC_JREGL = 6'h13;
  localparam logic [5:0] OPC_SHLI  = 6'h14;
  localparam logic [5:0] OPC_SHRI  = 6'h16;
  localparam logic [5:0] OPC_SARI  = 6'h17;
  localparam logic [5:0] OPC_EQI   = 6'h18;
  localparam logic [5:0] OPC_NEI   = 6'h19;
  localparam logic [5:0] OPC_LTI   = 6'h1a;
  localparam logic [5:0] OPC_LEI   = 6'h1c;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2b;
  localparam logic [5:0] OPC_STOP  = 6'h30;
  localparam logic [5:0] OPC_EMIT  = 6'h31;

  localparam logic [5:0] FN_NOP = 6'h00;
  localparam logic [5:0] FN_SHL = 6'h04;
  localparam logic [5:0] FN_SHR = 6'h06;
  localparam logic [5:0] FN_SAR = 6'h07;
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_XOR = 6'h26;
  localparam logic [5:0] FN_EQ  = 6'h28;
  localparam logic [5:0] FN_NE  = 6'h29;
  localparam logic [5:0] FN_LT  = 6'h2a;
  localparam logic [5:0] FN_LE  = 6'h2c;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR,
    ALU_EQ, ALU_NE, ALU_LT, ALU_LE,
    ALU_SHL, ALU_SHR, ALU_SAR, ALU_HIGH
  } alu_op_e;

  typedef enum logic [1:0] {
    WB_ALU, WB_MEM, WB_LINK
  } wb_sel_e;

  typedef struct packed {
    alu_op_e           alu_op;
    logic              use_imm;
    logic [XLEN-1:0]   imm;
    logic              reg_we;
    logic [RIDX_W-1:0] rs_idx;
    logic [RIDX_W-1:0] rt_idx;
    logic [RIDX_W-1:0] wr_idx;
    wb_sel_e           wb_sel;
    logic              is_store;
    logic              br_zero;
    logic              br_nonzero;
    logic              jmp_rel;
    logic              jmp_reg;
    logic              is_emit;
    logic              is_stop;
    logic              illegal;
  } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [31:0] instr,
  output ctrl_t       ctrl
);

  logic [5:0]      opc;
  logic [5:0]      fn;
  logic [XLEN-1:0] imm_s16;
  logic [XLEN-1:0] imm_z16;
  logic [XLEN-1:0] imm_s26;

  assign opc     = instr[31:26];
  assign fn      = instr[5:0];
  assign imm_s16 = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign imm_z16 = {{(XLEN-16){1'b0}}, instr[15:0]};
  assign imm_s26 = {{(XLEN-26){instr[25]}}, instr[25:0]};

  always_comb begin
    ctrl            = '0;
    ctrl.alu_op     = ALU_ADD;
    ctrl.wb_sel     = WB_ALU;
    ctrl.rs_idx     = instr[25:21];
    ctrl.rt_idx     = instr[20:16];
    ctrl.wr_idx     = instr[20:16];
    ctrl.imm        = imm_s16;
    unique case (opc)
      OPC_REG: begin
        ctrl.wr_idx = instr[15:11];
        ctrl.reg_we = 1'b1;
        unique case (fn)
          FN_ADD: ctrl.alu_op = ALU_ADD;
          FN_SUB: ctrl.alu_op = ALU_SUB;
          FN_AND: ctrl.alu_op = ALU_AND;
          FN_OR:  ctrl.alu_op = ALU_OR;
          FN_XOR: ctrl.alu_op = ALU_XOR;
          FN_EQ:  ctrl.alu_op = ALU_EQ;
          FN_NE:  ctrl.alu_op = ALU_NE;
          FN_LT:  ctrl.alu_op = ALU_LT;
          FN_LE:  ctrl.alu_op = ALU_LE;
          FN_SHL: ctrl.alu_op = ALU_SHL;
          FN_SHR: ctrl.alu_op = ALU_SHR;
          FN_SAR: ctrl.alu_op = ALU_SAR;
          FN_NOP: ctrl.reg_we = 1'b0;
          default: begin
            ctrl.reg_we  = 1'b0;
            ctrl.illegal = 1'b1;
          end
        endcase
      end
      OPC_JMP: begin
        ctrl.imm     = imm_s26;
        ctrl.jmp_rel = 1'b1;
      end
      OPC_JMPL: begin
        ctrl.imm     = imm_s26;
        ctrl.jmp_rel = 1'b1;
        ctrl.reg_we  = 1'b1;
        ctrl.wr_idx  = LINK_REG;
        ctrl.wb_sel  = WB_LINK;
      end
      OPC_BEZ: ctrl.br_zero    = 1'b1;
      OPC_BNZ: ctrl.br_nonzero = 1'b1;
      OPC_JREG: ctrl.jmp_reg   = 1'b1;
      OPC_JREGL: begin
        ctrl.jmp_reg = 1'b1;
        ctrl.reg_we  = 1'b1;
        ctrl.wr_idx  = LINK_REG;
        ctrl.wb_sel  = WB_LINK;
      end
      OPC_ADDI, OPC_SUBI, OPC_ANDI, OPC_ORI, OPC_XORI, OPC_HIGH,
      OPC_SHLI, OPC_SHRI, OPC_SARI, OPC_EQI, OPC_NEI, OPC_LTI, OPC_LEI: begin
        ctrl.use_imm = 1'b1;
        ctrl.reg_we  = 1'b1;
        unique case (opc)
          OPC_SUBI: ctrl.alu_op = ALU_SUB;
          OPC_ANDI: ctrl.alu_op = ALU_AND;
          OPC_ORI:  ctrl.alu_op = ALU_OR;
          OPC_XORI: begin
            ctrl.alu_op = ALU_XOR;
            ctrl.imm    = imm_z16;
          end
          OPC_HIGH: ctrl.alu_op = ALU_HIGH;
          OPC_SHLI: ctrl.alu_op = ALU_SHL;
          OPC_SHRI: ctrl.alu_op = ALU_SHR;
          OPC_SARI: ctrl.alu_op = ALU_SAR;
          OPC_EQI:  ctrl.alu_op = ALU_EQ;
          OPC_NEI:  ctrl.alu_op = ALU_NE;
          OPC_LTI:  ctrl.alu_op = ALU_LT;
          OPC_LEI:  ctrl.alu_op = ALU_LE;
          default:  ctrl.alu_op = ALU_ADD;
        endcase
      end
      OPC_LOAD: begin
        ctrl.reg_we = 1'b1;
        ctrl.wb_sel = WB_MEM;
      end
      OPC_STORE: ctrl.is_store = 1'b1;
      OPC_STOP:  ctrl.is_stop  = 1'b1;
      OPC_EMIT:  ctrl.is_emit  = 1'b1;
      default:   ctrl.illegal  = 1'b1;
    endcase
  end

  // R13: an unknown encoding must not request any state change
  always_comb begin
    if (ctrl.illegal) begin
      p_illegal_quiet_r13: assert (!ctrl.reg_we && !ctrl.is_store && !ctrl.is_emit);
    end
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y
);

  localparam int SH_W = $clog2(W);

  logic [SH_W-1:0] amt;
  assign amt = b[SH_W-1:0];

  always_comb begin
    unique case (op)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_AND:  y = a & b;
      ALU_OR:   y = a | b;
      ALU_XOR:  y = a ^ b;
      ALU_EQ:   y = W'(a == b);
      ALU_NE:   y = W'(a != b);
      ALU_LT:   y = W'(a < b);
      ALU_LE:   y = W'(a <= b);
      ALU_SHL:  y = a << amt;
      ALU_SHR:  y = a >> amt;
      ALU_SAR:  y = W'($signed(a) >>> amt);
      ALU_HIGH: y = {b[W/2-1:0], {(W/2){1'b0}}};
      default:  y = '0;
    endcase
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
  import sc_pkg::*;
#(
  parameter int W     = XLEN,
  parameter int IDX_W = RIDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] ra_idx,
  output logic [W-1:0]     ra_val,
  input  logic [IDX_W-1:0] rb_idx,
  output logic [W-1:0]     rb_val,
  input  logic             we,
  input  logic [IDX_W-1:0] w_idx,
  input  logic [W-1:0]     w_val
);

  localparam int DEPTH = 1 << IDX_W;

  logic [W-1:0] regs [DEPTH];

  assign ra_val = regs[ra_idx];
  assign rb_val = regs[rb_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (we) begin
      regs[w_idx] <= w_val;
    end
  end

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IADDR_W    = 16,
  parameter int DMEM_WORDS = 4096
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [XLEN-1:0]    prog_len,
  output logic [IADDR_W-1:0] imem_addr,
  input  logic [31:0]        imem_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [XLEN-1:0]    out_data,
  output logic               stopped,
  output logic               fault
);

  localparam int DADDR_W = $clog2(DMEM_WORDS);

  ctrl_t            ctrl;
  logic [XLEN-1:0]  pc;
  logic [XLEN-1:0]  pc_inc;
  logic [XLEN-1:0]  pc_next;
  logic [XLEN-1:0]  rs_val;
  logic [XLEN-1:0]  rt_val;
  logic [XLEN-1:0]  alu_b;
  logic [XLEN-1:0]  alu_y;
  logic [XLEN-1:0]  wb_val;
  logic [XLEN-1:0]  dm_rdata;
  logic [DADDR_W-1:0] dm_addr;
  logic             stall;
  logic             past_end;
  logic             exec;
  logic             taken;
  logic             rf_we;

  logic [XLEN-1:0]  dmem [DMEM_WORDS];

  sc_decode u_decode (
    .instr (imem_data),
    .ctrl  (ctrl)
  );

  sc_regfile #(.W(XLEN), .IDX_W(RIDX_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .ra_idx (ctrl.rs_idx),
    .ra_val (rs_val),
    .rb_idx (ctrl.rt_idx),
    .rb_val (rt_val),
    .we     (rf_we),
    .w_idx  (ctrl.wr_idx),
    .w_val  (wb_val)
  );

  assign alu_b = ctrl.use_imm ? ctrl.imm : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .op (ctrl.alu_op),
    .a  (rs_val),
    .b  (alu_b),
    .y  (alu_y)
  );

  assign imem_addr = pc[IADDR_W-1:0];
  assign stall     = out_valid && !out_ready;
  assign past_end  = pc >= prog_len;
  assign exec      = !stopped && !stall && !past_end && !ctrl.illegal;
  assign rf_we     = exec && ctrl.reg_we;

  assign dm_addr  = DADDR_W'(rs_val + ctrl.imm);
  assign dm_rdata = dmem[dm_addr];

  always_comb begin
    unique case (ctrl.wb_sel)
      WB_MEM:  wb_val = dm_rdata;
      WB_LINK: wb_val = pc + XLEN'(4);
      default: wb_val = alu_y;
    endcase
  end

  assign pc_inc = pc + XLEN'(1);
  assign taken  = (ctrl.br_zero && (rs_val == '0)) ||
                  (ctrl.br_nonzero && (rs_val != '0)) ||
                  ctrl.jmp_rel;

  always_comb begin
    if (ctrl.jmp_reg)   pc_next = rs_val;
    else if (taken)     pc_next = pc_inc + ctrl.imm;
    else if (ctrl.is_stop) pc_next = pc;
    else                pc_next = pc_inc;
  end

  always_ff @(posedge clk) begin
    if (exec && ctrl.is_store) dmem[dm_addr] <= rt_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc        <= '0;
      stopped   <= 1'b0;
      fault     <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (!stopped && !stall) begin
        if (past_end) begin
          stopped <= 1'b1;
        end else if (ctrl.illegal) begin
          stopped <= 1'b1;
          fault   <= 1'b1;
        end else begin
          pc <= pc_next;
          if (ctrl.is_stop) stopped <= 1'b1;
          if (ctrl.is_emit) begin
            out_valid <= 1'b1;
            out_data  <= rs_val;
          end
        end
      end
    end
  end

  // R11: once stopped, the core stays stopped and the PC is frozen
  p_stop_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |=> stopped && $stable(pc));

  // R10: an unaccepted value is held and the core does not advance
  p_emit_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(pc));

  // R13: a fault always comes with a stopped core
  p_fault_stops_r13: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> stopped);

  // R13: the fault flag never clears before reset
  p_fault_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);

  // R12: reaching the end of the program stops the core without a fault
  p_end_stop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !stopped && !stall && past_end |=> stopped && !fault);

endmodule

// File: tb/test_sc_core.sv
module test_sc_core;
  import sc_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int IW = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [31:0]     prog_len = '0;
  logic [IW-1:0]   imem_addr;
  logic [31:0]     imem_data;
  logic            out_valid;
  logic            out_ready;
  logic [31:0]     out_data;
  logic            stopped;
  logic            fault;

  logic [31:0] rom [64];
  logic [31:0] exp_q [$];
  string       req_q [$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign imem_data = rom[imem_addr[5:0]];

  sc_core #(.IADDR_W(IW), .DMEM_WORDS(4096)) i_sc_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_len  (prog_len),
    .imem_addr (imem_addr),
    .imem_data (imem_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .stopped   (stopped),
    .fault     (fault)
  );

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [4:0] rd);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] off);
    return {op, off};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic expect_out(input logic [31:0] v, input string req);
    exp_q.push_back(v);
    req_q.push_back(req);
  endtask

  task automatic begin_prog();
    rst_n = 1'b0;
    for (int i = 0; i < 64; i++) rom[i] = enc_i(OPC_STOP, 0, 0, 0);
    exp_q.delete();
    req_q.delete();
  endtask

  task automatic release_reset(input logic [31:0] len);
    prog_len = len;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(imem_addr == 0, "R1", "pc after reset", 32'(imem_addr), 0);
    check(!stopped && !fault && !out_valid, "R1", "flags after reset",
          {29'd0, stopped, fault, out_valid}, 0);
  endtask

  task automatic wait_stop(input string req, input bit exp_fault, input int exp_pc);
    int n;
    n = 0;
    while (!stopped && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(stopped, req, "core stopped", 32'(stopped), 1);
    repeat (8) @(negedge clk);
    #2;
    check(fault == exp_fault, req, "fault flag", 32'(fault), 32'(exp_fault));
    check(imem_addr == IW'(exp_pc), req, "frozen pc", 32'(imem_addr), 32'(exp_pc));
    check(stopped, "R11", "stopped held", 32'(stopped), 1);
    check(exp_q.size() == 0 && !out_valid, "R10", "all values delivered",
          32'(exp_q.size()), 0);
  endtask

  // Monitor and scoreboard: drives out_ready in a repeating pattern and
  // compares each delivered value with the next expected one.
  initial begin
    int rcnt;
    bit held;
    logic [IW-1:0] held_pc;
    logic [31:0] e;
    string r;
    rcnt = 0;
    held = 1'b0;
    held_pc = '0;
    out_ready = 1'b0;
    forever begin
      @(negedge clk);
      rcnt++;
      out_ready = (rcnt % 5 != 1) && (rcnt % 7 != 3);
      #1;
      if (rst_n) begin
        if (held)
          check(imem_addr == held_pc, "R10", "pc held while stalled",
                32'(imem_addr), 32'(held_pc));
        held = 1'b0;
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R10", "unexpected value", out_data, 0);
          end else begin
            e = exp_q.pop_front();
            r = req_q.pop_front();
            check(out_data == e, r, "emitted value", out_data, e);
          end
        end else if (out_valid) begin
          held = 1'b1;
          held_pc = imem_addr;
        end
      end else begin
        held = 1'b0;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      check(1'b0, "R11", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    // Program A: arithmetic, memory, branches, links, back-to-back emits
    begin_prog();
    rom[0]  = enc_i(OPC_ORI, 0, 1, 16'd5);              expect_out(32'd5, "R2");
    rom[1]  = enc_i(OPC_EMIT, 1, 0, 0);
    rom[2]  = enc_i(OPC_ADDI, 1, 2, 16'hFFFD);          expect_out(32'd2, "R4");
    rom[3]  = enc_i(OPC_EMIT, 2, 0, 0);
    rom[4]  = enc_i(OPC_XORI, 0, 3, 16'hFFFF);          expect_out(32'h0000FFFF, "R4");
    rom[5]  = enc_i(OPC_EMIT, 3, 0, 0);
    rom[6]  = enc_i(OPC_ORI, 0, 4, 16'hFFFF);           expect_out(32'hFFFFFFFF, "R4");
    rom[7]  = enc_i(OPC_EMIT, 4, 0, 0);
    rom[8]  = enc_i(OPC_HIGH, 0, 5, 16'h8001);          expect_out(32'h80010000, "R5");
    rom[9]  = enc_i(OPC_EMIT, 5, 0, 0);
    rom[10] = enc_r(FN_SUB, 2, 1, 6);                   expect_out(32'hFFFFFFFD, "R3");
    rom[11] = enc_i(OPC_EMIT, 6, 0, 0);
    rom[12] = enc_r(FN_LT, 6, 1, 7);                    expect_out(32'd0, "R3");
    rom[13] = enc_i(OPC_EMIT, 7, 0, 0);
    rom[14] = enc_r(FN_SAR, 5, 2, 8);                   expect_out(32'hE0004000, "R3");
    rom[15] = enc_i(OPC_EMIT, 8, 0, 0);
    rom[16] = enc_i(OPC_SHRI, 5, 9, 16'd4);             expect_out(32'h08001000, "R4");
    rom[17] = enc_i(OPC_EMIT, 9, 0, 0);
    rom[18] = enc_i(OPC_STORE, 2, 1, 16'hFFFF);
    rom[19] = enc_i(OPC_LOAD, 0, 10, 16'd1);            expect_out(32'd5, "R6");
    rom[20] = enc_i(OPC_EMIT, 10, 0, 0);
    rom[21] = enc_i(OPC_ORI, 0, 11, 16'd3);
    rom[22] = enc_i(OPC_EMIT, 11, 0, 0);                expect_out(32'd3, "R7");
    rom[23] = enc_i(OPC_SUBI, 11, 11, 16'd1);           expect_out(32'd2, "R7");
    rom[24] = enc_i(OPC_BNZ, 11, 0, 16'hFFFD);          expect_out(32'd1, "R7");
    rom[25] = enc_i(OPC_BEZ, 11, 0, 16'd1);
    rom[26] = enc_i(OPC_EMIT, 1, 0, 0);
    rom[27] = enc_j(OPC_JMPL, 26'd2);                   expect_out(32'd31, "R9");
    rom[28] = enc_i(OPC_EMIT, 1, 0, 0);
    rom[29] = enc_i(OPC_EMIT, 1, 0, 0);
    rom[30] = enc_i(OPC_EMIT, 31, 0, 0);
    rom[31] = enc_i(OPC_ORI, 0, 12, 16'd34);
    rom[32] = enc_i(OPC_JREGL, 12, 0, 0);               expect_out(32'd36, "R8");
    rom[33] = enc_i(OPC_EMIT, 1, 0, 0);
    rom[34] = enc_i(OPC_EMIT, 31, 0, 0);
    rom[35] = enc_j(OPC_JMP, 26'd1);
    rom[36] = enc_i(OPC_EMIT, 1, 0, 0);
    rom[37] = enc_i(OPC_ORI, 0, 0, 16'd7);              expect_out(32'd7, "R4");
    rom[38] = enc_i(OPC_EMIT, 0, 0, 0);
    rom[39] = enc_r(FN_NOP, 1, 1, 1);                   expect_out(32'd5, "R3");
    rom[40] = enc_i(OPC_EMIT, 1, 0, 0);
    rom[41] = enc_r(FN_EQ, 1, 10, 13);                  expect_out(32'd1, "R3");
    rom[42] = enc_i(OPC_EMIT, 13, 0, 0);                expect_out(32'd7, "R10");
    rom[43] = enc_i(OPC_EMIT, 0, 0, 0);
    rom[44] = enc_i(OPC_STOP, 0, 0, 0);
    rom[45] = enc_i(OPC_EMIT, 1, 0, 0);
    release_reset(32'd46);
    wait_stop("R11", 1'b0, 44);

    // Program B: register jump, then run off the end of the program
    begin_prog();
    rom[0] = enc_i(OPC_ORI, 0, 2, 16'd3);
    rom[1] = enc_i(OPC_JREG, 2, 0, 0);
    rom[2] = enc_i(OPC_EMIT, 1, 0, 0);
    rom[3] = enc_i(OPC_EMIT, 2, 0, 0);                  expect_out(32'd3, "R8");
    rom[4] = enc_i(OPC_EMIT, 2, 0, 0);
    release_reset(32'd4);
    wait_stop("R12", 1'b0, 4);

    // Program C: unknown funct in register-register format
    begin_prog();
    rom[0] = enc_r(6'h3f, 1, 1, 1);
    rom[1] = enc_i(OPC_EMIT, 0, 0, 0);
    release_reset(32'd10);
    wait_stop("R13", 1'b1, 0);

    // Program D: unknown opcode after some work
    begin_prog();
    rom[0] = enc_i(OPC_ORI, 0, 1, 16'd4);
    rom[1] = enc_i(OPC_EMIT, 1, 0, 0);                  expect_out(32'd4, "R13");
    rom[2] = enc_i(6'h3e, 1, 1, 16'd0);
    rom[3] = enc_i(OPC_EMIT, 1, 0, 0);
    release_reset(32'd10);
    wait_stop("R13", 1'b1, 2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule